// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a compact multicycle processor for a 32-bit load/store instruction set. It holds thirty-two 32-bit general registers, a program counter and an instruction register. One word-wide memory port carries both instruction fetches and data accesses. Each instruction passes through a fetch step, a decode/execute step, an optional memory step and a write-back step. Every memory step holds its request until the memory answers with a ready pulse, so both slow and single-cycle memories can be attached.

The supported operations are: loads, stores and address loads with a base-plus-constant address; a second family of these that is relative to the program counter; immediate add, AND and OR; four immediate-count shifts; a no-op; and a stop instruction that freezes the core and raises a halted flag. A base register field of zero means "no base", so the same instruction covers direct and indexed addressing.

Top module: `mcc_core`

## Requirements
- R1: After reset the program counter and all 32 registers read zero and `halted` is low. The first memory request is a read of byte address 0.
- R2: A request (`mem_req` high) keeps `mem_addr`, `mem_we` and `mem_wdata` unchanged until a clock edge that samples `mem_ready` high. Each such edge completes exactly one transfer, and read data is taken from `mem_rdata` at that edge.
- R3: Instructions are fetched from consecutive word addresses 0, 4, 8, ... Fields are: opcode [31:27], ra [26:22], rb [21:17], c2 [16:0], c1 [21:0], shift count c3 [4:0].
- R4: Opcode 1 loads ra from M[c2 + base], opcode 3 stores ra to that address, and opcode 5 writes the address itself into ra. The base is 0 when rb = 0, even if R0 holds a nonzero value, and R[rb] otherwise.
- R5: c2 is sign-extended from 17 bits before any use. The word address put on the port has bits [1:0] cleared.
- R6: Opcode 2 loads ra from M[PC + c1], opcode 4 stores ra there, and opcode 6 writes PC + c1 into ra. Here PC is the address of the instruction plus 4, and c1 is sign-extended from 22 bits.
- R7: Opcode 13 writes R[rb] + c2 into ra, opcode 21 writes R[rb] AND c2, and opcode 23 writes R[rb] OR c2. All three use the sign-extended c2 and read R[rb] even when rb = 0.
- R8: Opcodes 26, 27, 28 and 29 write R[rb] into ra after, in that order, a logical right shift, an arithmetic right shift, a left shift, or a left rotate by c3. A count of 0 passes the value through unchanged.
- R9: Opcode 0, and every opcode not listed above, changes no register and makes no data access. The next fetch follows at once.
- R10: Opcode 31 raises `halted`, which then stays high until reset, and no further memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the pending request |
| halted | output | 1 | High once stop has executed |

## Verification
A single program exercises every opcode. Stores expose each result on the port, where a scoreboard compares it along with every fetch and load address. R0 is first loaded with a nonzero value, so a direct access that wrongly used R0 as a base lands on a different address. Negative constants separate sign extension from zero extension, and a shifted value with its top bit set makes the logical and arithmetic right shifts produce different results. A zero rotate count, an undefined opcode aimed at a register that is still zero, and memory latencies that cycle between 0 and 2 wait cycles cover the edge cases of write-back and the handshake.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam logic [4:0] OP_NOP  = 5'd0;
  localparam logic [4:0] OP_LD   = 5'd1;
  localparam logic [4:0] OP_LDR  = 5'd2;
  localparam logic [4:0] OP_ST   = 5'd3;
  localparam logic [4:0] OP_STR  = 5'd4;
  localparam logic [4:0] OP_LA   = 5'd5;
  localparam logic [4:0] OP_LAR  = 5'd6;
  localparam logic [4:0] OP_ADDI = 5'd13;
  localparam logic [4:0] OP_ANDI = 5'd21;
  localparam logic [4:0] OP_ORI  = 5'd23;
  localparam logic [4:0] OP_SHR  = 5'd26;
  localparam logic [4:0] OP_SHRA = 5'd27;
  localparam logic [4:0] OP_SHL  = 5'd28;
  localparam logic [4:0] OP_SHC  = 5'd29;
  localparam logic [4:0] OP_STOP = 5'd31;

  typedef enum logic [2:0] {
    ST_FETCH, ST_EXEC, ST_MEM, ST_WB, ST_HALT
  } phase_e;

  function automatic logic [31:0] sext_short(input logic [16:0] v);
    return {{15{v[16]}}, v};
  endfunction

  function automatic logic [31:0] sext_long(input logic [21:0] v);
    return {{10{v[21]}}, v};
  endfunction

  function automatic logic [31:0] shift_word(input logic [4:0] op,
                                             input logic [31:0] v,
                                             input logic [4:0] n);
    logic [63:0] dbl;
    dbl = {v, v} << n;
    case (op)
      OP_SHR:  return v >> n;
      OP_SHRA: return 32'($signed(v) >>> n);
      OP_SHL:  return v << n;
      default: return dbl[63:32];
    endcase
  endfunction
endpackage

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a,
  input  logic [IW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))    regs[g] <= wr_data;
    end
  end

  assign rd_a = regs[rd_a_idx];
  assign rd_b = regs[rd_b_idx];
endmodule

// File: rtl/mcc_exec.sv
module mcc_exec
  import mcc_pkg::*;
(
  input  logic [31:0] ir,
  input  logic [31:0] pc,
  input  logic [31:0] rb_val,
  output logic [31:0] result,
  output logic [31:0] eff_addr,
  output logic        is_mem,
  output logic        is_store,
  output logic        wr_reg,
  output logic        is_stop
);
  logic [4:0]  op;
  logic [31:0] c2x, c1x, base, abs_sum, rel_sum;

  assign op      = ir[31:27];
  assign c2x     = sext_short(ir[16:0]);
  assign c1x     = sext_long(ir[21:0]);
  assign base    = (ir[21:17] == 5'd0) ? 32'd0 : rb_val;
  assign abs_sum = base + c2x;
  assign rel_sum = pc + c1x;

  always_comb begin
    result   = '0;
    eff_addr = '0;
    is_mem   = 1'b0;
    is_store = 1'b0;
    wr_reg   = 1'b0;
    is_stop  = 1'b0;
    case (op)
      OP_LD:   begin is_mem = 1'b1; eff_addr = {abs_sum[31:2], 2'b00}; end
      OP_ST:   begin is_mem = 1'b1; is_store = 1'b1; eff_addr = {abs_sum[31:2], 2'b00}; end
      OP_LA:   begin wr_reg = 1'b1; result = abs_sum; end
      OP_LDR:  begin is_mem = 1'b1; eff_addr = {rel_sum[31:2], 2'b00}; end
      OP_STR:  begin is_mem = 1'b1; is_store = 1'b1; eff_addr = {rel_sum[31:2], 2'b00}; end
      OP_LAR:  begin wr_reg = 1'b1; result = rel_sum; end
      OP_ADDI: begin wr_reg = 1'b1; result = rb_val + c2x; end
      OP_ANDI: begin wr_reg = 1'b1; result = rb_val & c2x; end
      OP_ORI:  begin wr_reg = 1'b1; result = rb_val | c2x; end
      OP_SHR, OP_SHRA, OP_SHL, OP_SHC:
               begin wr_reg = 1'b1; result = shift_word(op, rb_val, ir[4:0]); end
      OP_STOP: is_stop = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mcc_core.sv
module mcc_core
  import mcc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ready,
  output logic            halted
);
  phase_e          phase;
  logic [XLEN-1:0] pc, ir, addr_q, wdata_q, res_q;
  logic            we_q;
  logic [XLEN-1:0] ra_val, rb_val, x_res, x_addr;
  logic            x_mem, x_store, x_wr, x_stop;

  // named events used by the assertions
  logic fetch_done, mem_done, wb_fire;
  assign fetch_done = (phase == ST_FETCH) && mem_ready;
  assign mem_done   = (phase == ST_MEM) && mem_ready;
  assign wb_fire    = (phase == ST_WB);

  mcc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ir[26:22]), .rd_a(ra_val),
    .rd_b_idx(ir[21:17]), .rd_b(rb_val),
    .wr_en(wb_fire), .wr_idx(ir[26:22]), .wr_data(res_q)
  );

  mcc_exec u_exec (
    .ir(ir), .pc(pc), .rb_val(rb_val),
    .result(x_res), .eff_addr(x_addr),
    .is_mem(x_mem), .is_store(x_store), .wr_reg(x_wr), .is_stop(x_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_FETCH;
      pc      <= '0;
      ir      <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      res_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      case (phase)
        ST_FETCH: if (mem_ready) begin
          ir    <= mem_rdata;
          pc    <= pc + XLEN'(4);
          phase <= ST_EXEC;
        end
        ST_EXEC: begin
          if (x_stop) phase <= ST_HALT;
          else if (x_mem) begin
            addr_q  <= x_addr;
            wdata_q <= ra_val;
            we_q    <= x_store;
            phase   <= ST_MEM;
          end else if (x_wr) begin
            res_q <= x_res;
            phase <= ST_WB;
          end else phase <= ST_FETCH;
        end
        ST_MEM: if (mem_ready) begin
          if (we_q) phase <= ST_FETCH;
          else begin
            res_q <= mem_rdata;
            phase <= ST_WB;
          end
        end
        ST_WB:   phase <= ST_FETCH;
        default: phase <= ST_HALT;
      endcase
    end
  end

  assign mem_req   = (phase == ST_FETCH) || (phase == ST_MEM);
  assign mem_we    = (phase == ST_MEM) && we_q;
  assign mem_addr  = (phase == ST_MEM) ? addr_q : pc;
  assign mem_wdata = (phase == ST_MEM && we_q) ? wdata_q : '0;
  assign halted    = (phase == ST_HALT);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (pc == $past(pc) + XLEN'(4)));
  // R9
  wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> ($past(phase) == ST_EXEC || $past(mem_done)));
endmodule

// File: tb/mcc_core_bench.sv
module mcc_core_bench;
  localparam time TCLK = 10ns;
  localparam int  MAXCYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, mem_ready = 1'b0, halted;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  always #(TCLK/2) clk = ~clk;

  mcc_core u_mcc_core (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .halted(halted)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } xact_t;

  xact_t       expq[$];
  logic [31:0] mem [256];
  int          nvec = 0, nbad = 0, nserv = 0, wait_cnt = 0;
  logic [31:0] lpc = 0;

  function automatic logic [31:0] enc_c(int op, int ra, int rb, int c2);
    logic [4:0] o = 5'(op), a = 5'(ra), b = 5'(rb);
    return {o, a, b, 17'(c2)};
  endfunction
  function automatic logic [31:0] enc_b(int op, int ra, int c1);
    logic [4:0] o = 5'(op), a = 5'(ra);
    return {o, a, 22'(c1)};
  endfunction

  task automatic expect_x(bit we, logic [31:0] a, logic [31:0] d, string tag);
    xact_t e;
    e.we = we; e.addr = a; e.data = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic place(logic [31:0] w, string tag);
    mem[lpc[9:2]] = w;
    expect_x(1'b0, lpc, '0, tag);
    lpc = lpc + 4;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      wait_cnt  <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      wait_cnt  <= 0;
    end else if (mem_req) begin
      if (wait_cnt >= nserv % 3) begin
        mem_ready <= 1'b1;
        nserv     <= nserv + 1;
        if (expq.size() == 0) check(1'b0, "R10 unexpected request", mem_addr, 32'hFFFF_FFFF);
        else begin
          xact_t e;
          e = expq.pop_front();
          check(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
                e.tag, e.we ? mem_wdata : mem_addr, e.we ? e.data : e.addr);
        end
        if (mem_addr[31:10] != 0) check(1'b0, "R5 address range", mem_addr, 32'h0);
        else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[9:2]];
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  initial begin
    logic [31:0] v2, v3;
    int cyc;
    bit quiet;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    v2 = 32'h8000_00F0;
    v3 = 32'h1234_5678;
    mem['h200 >> 2] = v2;
    mem['h104 >> 2] = v3;

    place(enc_c(13, 0, 0, 64), "R1 first fetch at 0");                  // R0 = 64
    place(enc_c(5, 1, 0, 'h100), "R3 fetch");                           // la R1
    place(enc_c(1, 2, 0, 'h200), "R3 fetch");
    expect_x(0, 32'h200, '0, "R4 direct ld ignores R0");
    place(enc_c(1, 3, 1, 4), "R3 fetch");
    expect_x(0, 32'h104, '0, "R4 indexed ld");
    place(enc_c(13, 4, 2, -16), "R3 fetch");
    place(enc_c(3, 4, 0, 'h300), "R3 fetch");
    expect_x(1, 32'h300, v2 - 32'd16, "R7 addi negative c2");
    place(enc_c(21, 5, 3, 'h0FF0), "R3 fetch");
    place(enc_c(3, 5, 1, 8), "R3 fetch");
    expect_x(1, 32'h108, v3 & 32'h0FF0, "R7 andi / R4 indexed st");
    place(enc_c(23, 6, 3, 'hF), "R3 fetch");
    place(enc_c(3, 6, 0, 'h304), "R3 fetch");
    expect_x(1, 32'h304, v3 | 32'hF, "R7 ori");
    place(enc_c(26, 7, 2, 4), "R3 fetch");
    place(enc_c(3, 7, 0, 'h308), "R3 fetch");
    expect_x(1, 32'h308, v2 >> 4, "R8 logical right");
    place(enc_c(27, 7, 2, 4), "R3 fetch");
    place(enc_c(3, 7, 0, 'h30C), "R3 fetch");
    expect_x(1, 32'h30C, {4'hF, v2[31:4]}, "R8 arithmetic right");
    place(enc_c(28, 7, 2, 4), "R3 fetch");
    place(enc_c(3, 7, 0, 'h310), "R3 fetch");
    expect_x(1, 32'h310, v2 << 4, "R8 left");
    place(enc_c(29, 7, 2, 4), "R3 fetch");
    place(enc_c(3, 7, 0, 'h314), "R3 fetch");
    expect_x(1, 32'h314, {v2[27:0], v2[31:28]}, "R8 rotate");
    begin
      logic [31:0] lar_exp;
      lar_exp = lpc + 4 + 100;
      place(enc_b(6, 8, 100), "R3 fetch");
      place(enc_c(3, 8, 0, 'h318), "R3 fetch");
      expect_x(1, 32'h318, lar_exp, "R6 lar uses incremented PC");
    end
    place(enc_b(2, 9, int'(32'h200 - (lpc + 4))), "R3 fetch");
    expect_x(0, 32'h200, '0, "R6 ldr address");
    place(enc_b(4, 9, int'(32'h31C - (lpc + 4))), "R3 fetch");
    expect_x(1, 32'h31C, v2, "R6 str address and data");
    place(enc_c(5, 10, 0, -8), "R3 fetch");
    place(enc_c(3, 10, 0, 'h320), "R3 fetch");
    expect_x(1, 32'h320, 32'hFFFF_FFF8, "R5 sign-extended c2");
    place(enc_c(0, 0, 0, 0), "R9 nop then next fetch");
    place(enc_c(7, 11, 2, 5), "R9 undefined opcode then next fetch");
    place(enc_c(3, 11, 0, 'h324), "R3 fetch");
    expect_x(1, 32'h324, 32'h0, "R9 undefined opcode left R11 / R1 reset value");
    place(enc_c(29, 12, 3, 0), "R3 fetch");
    place(enc_c(3, 12, 0, 'h329), "R3 fetch");
    expect_x(1, 32'h328, v3, "R8 zero count / R5 low bits cleared");
    place(enc_c(31, 0, 0, 0), "R10 stop fetched");

    #(TCLK*2);
    check(halted == 1'b0, "R1 halted low in reset", {31'd0, halted}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc = 0;
    while (!halted && cyc < MAXCYC) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) check(1'b0, "watchdog R10", 32'(cyc), 32'(MAXCYC));
    else begin
      check(expq.size() == 0, "R10 all transfers seen", 32'(expq.size()), 32'd0);
      quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (mem_req || !halted) quiet = 1'b0;
      end
      check(quiet, "R10 halted holds, no requests", {31'd0, quiet}, 32'd1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule